// File: doc/BRIEF.md
# SDRAM Power-Up Initialization and Refresh Sequencer

This block owns the command pins of a two-bank synchronous DRAM from the moment reset is released. It first idles the device with clock enable and data mask held high for the power-up settling time. It then closes both banks, runs a fixed number of auto-refresh cycles and loads the mode register with a value supplied on its inputs. After that it reports the memory as ready and keeps the stored rows alive by issuing one auto-refresh every refresh interval.

Refresh is negotiated with the client that issues data traffic. When an interval expires, the block raises its busy flag and waits. The client finishes or parks its own work and signals that the memory is idle. Only then does the block close both banks, refresh and hand the pins back.

All timing windows are given in nanoseconds and converted to clock cycles from a clock-period parameter. Waits round up. The per-row refresh interval is the refresh window divided by the row count and rounds down, so refreshes are never late.

Top module: `sdram_init_refresh`

## Requirements
- R1: During reset and for WAIT cycles after it, where WAIT = ceil(200000 ns / clock period), clock enable and DQM are high and chip select is high. The first command appears exactly WAIT cycles after release.
- R2: The first command is a precharge of both banks: RAS low, CAS high, WE low (command code {ras,cas,we} = 3'b010), with address bit 10 set and all other address bits and the bank bit zero.
- R3: Two auto-refresh commands follow, with code 3'b001 and address and bank zero. The first comes TRP = ceil(tRP/period) cycles after the precharge and the second comes TRC = ceil(tRC/period) cycles after the first.
- R4: TRC cycles after the second refresh, a mode register write is issued: code 3'b000, address equal to mode_word and bank equal to mode_bank. It is the only such command and it occurs only while init_done is low.
- R5: init_done goes high exactly 2 cycles after the mode register write and stays high. DQM goes low in that same cycle.
- R6: refresh_busy goes high REF = floor((32 ms / 2048) / period) cycles after init_done rises, and again every REF cycles after that.
- R7: While refresh_busy is high and client_idle is low, no command is issued and refresh_busy stays high.
- R8: In the cycle after client_idle is seen high with refresh_busy high, a both-bank precharge (3'b010, A10 set) is issued. An auto-refresh follows TRP cycles later, and refresh_busy falls TRC cycles after the auto-refresh.
- R9: In every cycle without a command, chip select is high and RAS, CAS and WE are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ADDR_W | Operation code placed on the address bus by the mode write |
| mode_bank | input | 1 | Bank bit driven with the mode write |
| client_idle | input | 1 | Client grants a pending refresh |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_bank | output | 1 | Bank select |
| sd_dqm | output | 1 | Data mask, high until initialization ends |
| init_done | output | 1 | Initialization complete |
| refresh_busy | output | 1 | Refresh pending or running |

## Verification
Every command is due a fixed number of cycles after a known event. The precharge comes WAIT cycles after reset release. Each following init command comes TRP or TRC cycles after the one before, init_done comes 2 cycles after the mode write, and the busy flag comes REF cycles after init_done. A granted refresh starts 1 cycle after the grant is sampled. The bench derives each of these cycle numbers from the timing parameters and queues the expected command with its cycle. A monitor samples the pins on the falling edge, pops the queue on every active chip select and compares the cycle, code, address and bank, so a command that is early, late or not expected is reported. Flag checks wait for the exact cycle number and also check the cycle just before it.

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh #(
  parameter int CLK_NS      = 20,
  parameter int POWERUP_NS  = 200000,
  parameter int WINDOW_NS   = 32000000,
  parameter int ROWS        = 2048,
  parameter int TRP_NS      = 20,
  parameter int TRC_NS      = 70,
  parameter int INIT_REFS   = 2,
  parameter int MODE_GUARD  = 2,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              mode_bank,
  input  logic              client_idle,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_bank,
  output logic              sd_dqm,
  output logic              init_done,
  output logic              refresh_busy
);
  localparam int WAIT_CYC = (POWERUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRP_CYC  = (TRP_NS + CLK_NS - 1) / CLK_NS;
  localparam int TRC_CYC  = (TRC_NS + CLK_NS - 1) / CLK_NS;
  localparam int REF_CYC  = (WINDOW_NS / ROWS) / CLK_NS;
  localparam int M1 = (WAIT_CYC > TRC_CYC) ? WAIT_CYC : TRC_CYC;
  localparam int M2 = (M1 > TRP_CYC) ? M1 : TRP_CYC;
  localparam int MAXD = (M2 > MODE_GUARD) ? M2 : MODE_GUARD;
  localparam int CW  = $clog2(MAXD + 1);
  localparam int RW  = $clog2(REF_CYC + 1);
  localparam int NW  = $clog2(INIT_REFS + 1);
  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  typedef enum logic [2:0] {PWR, I_PALL, I_AREF, I_MRS, IDLE, R_PALL, R_AREF} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] tmr;
  logic [NW-1:0] nref;
  logic fresh, pend, done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PWR; cnt <= CW'(WAIT_CYC - 1); tmr <= RW'(REF_CYC - 1);
      nref <= '0; fresh <= 1'b0; pend <= 1'b0; done_r <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (st != IDLE && cnt != 0) cnt <= cnt - 1'b1;
      else case (st)
        PWR:    begin st <= I_PALL; cnt <= CW'(TRP_CYC - 1); fresh <= 1'b1; end
        I_PALL: begin st <= I_AREF; cnt <= CW'(TRC_CYC - 1); fresh <= 1'b1; nref <= '0; end
        I_AREF: begin
          fresh <= 1'b1;
          if (nref == NW'(INIT_REFS - 1)) begin st <= I_MRS; cnt <= CW'(MODE_GUARD - 1); end
          else begin nref <= nref + 1'b1; cnt <= CW'(TRC_CYC - 1); end
        end
        I_MRS:  begin st <= IDLE; done_r <= 1'b1; end
        IDLE:   if (pend && client_idle) begin
                  st <= R_PALL; cnt <= CW'(TRP_CYC - 1); fresh <= 1'b1; pend <= 1'b0;
                end
        R_PALL: begin st <= R_AREF; cnt <= CW'(TRC_CYC - 1); fresh <= 1'b1; end
        R_AREF: st <= IDLE;
        default: st <= IDLE;
      endcase
      if (done_r) begin
        if (tmr == 0) begin tmr <= RW'(REF_CYC - 1); pend <= 1'b1; end
        else tmr <= tmr - 1'b1;
      end
    end
  end

  wire is_pall = fresh && (st == I_PALL || st == R_PALL);
  wire is_ref  = fresh && (st == I_AREF || st == R_AREF);
  wire is_mrs  = fresh && (st == I_MRS);

  assign sd_cke       = 1'b1;
  assign sd_cs_n      = !(is_pall || is_ref || is_mrs);
  assign sd_ras_n     = !(is_pall || is_ref || is_mrs);
  assign sd_cas_n     = !(is_ref || is_mrs);
  assign sd_we_n      = !(is_pall || is_mrs);
  assign sd_addr      = is_mrs ? mode_word : (is_pall ? AP_MASK : '0);
  assign sd_bank      = is_mrs && mode_bank;
  assign sd_dqm       = !done_r;
  assign init_done    = done_r;
  assign refresh_busy = pend || st == R_PALL || st == R_AREF;

  p_nop_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n));
  p_pall_ap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[AP_BIT]);
  p_mode_before_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> !init_done);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_dqm_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> sd_dqm);
  p_cmd_in_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !sd_cs_n) |-> refresh_busy);
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && refresh_busy && !client_idle) |=> (sd_cs_n && refresh_busy));
endmodule

// File: tb/sdram_init_refresh_test.sv
module sdram_init_refresh_test;
  localparam int PER   = 20;
  localparam int WAIT  = (200000 + PER - 1) / PER;
  localparam int TRP   = (20 + PER - 1) / PER;
  localparam int TRC   = (70 + PER - 1) / PER;
  localparam int REF   = (32000000 / 2048) / PER;
  localparam int MRS_AT = WAIT + TRP + 2 * TRC;
  localparam int D     = MRS_AT + 2;
  localparam int HOLD  = D + 2 * REF + 40;

  logic clk = 0, rst_n = 0, mode_bank = 0, client_idle = 1;
  logic [10:0] mode_word = 11'h232;
  logic cke, cs_n, ras_n, cas_n, we_n, bank, dqm, done, busy;
  logic [10:0] addr;
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  int q_cyc[$]; logic [2:0] q_cmd[$]; logic [10:0] q_addr[$]; logic q_bank[$]; string q_tag[$];

  sdram_init_refresh uut (.clk(clk), .rst_n(rst_n), .mode_word(mode_word), .mode_bank(mode_bank),
    .client_idle(client_idle), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_addr(addr), .sd_bank(bank), .sd_dqm(dqm), .init_done(done),
    .refresh_busy(busy));

  always #(PER/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic expect_cmd(int c, logic [2:0] cmd, logic [10:0] a, logic b, string tag);
    q_cyc.push_back(c); q_cmd.push_back(cmd); q_addr.push_back(a); q_bank.push_back(b); q_tag.push_back(tag);
  endtask

  task automatic at_cyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (!(cs_n && !(ras_n && cas_n && we_n)))
      ;
    else chk(0, "R9", "strobe low without chip select", {ras_n, cas_n, we_n}, 7);
    if (!cs_n) begin
      if (q_cyc.size() == 0) chk(0, "R7", "unexpected command code", {ras_n, cas_n, we_n}, -1);
      else begin
        int ec; logic [2:0] em; logic [10:0] ea; logic eb; string et;
        ec = q_cyc.pop_front(); em = q_cmd.pop_front(); ea = q_addr.pop_front();
        eb = q_bank.pop_front(); et = q_tag.pop_front();
        chk(cyc == ec, et, "command cycle", cyc, ec);
        chk({ras_n, cas_n, we_n} == em, et, "command code", {ras_n, cas_n, we_n}, em);
        chk(addr == ea, et, "address", addr, ea);
        chk(bank == eb, et, "bank", bank, eb);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1; fails++; checks++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    expect_cmd(WAIT, 3'b010, 11'h400, 0, "R2");
    expect_cmd(WAIT + TRP, 3'b001, 11'h000, 0, "R3");
    expect_cmd(WAIT + TRP + TRC, 3'b001, 11'h000, 0, "R3");
    expect_cmd(MRS_AT, 3'b000, 11'h232, 0, "R4");
    expect_cmd(D + REF + 1, 3'b010, 11'h400, 0, "R8");
    expect_cmd(D + REF + 1 + TRP, 3'b001, 11'h000, 0, "R8");
    expect_cmd(HOLD + 1, 3'b010, 11'h400, 0, "R8");
    expect_cmd(HOLD + 1 + TRP, 3'b001, 11'h000, 0, "R8");
    expect_cmd(D + 3 * REF + 1, 3'b010, 11'h400, 0, "R6");
    expect_cmd(D + 3 * REF + 1 + TRP, 3'b001, 11'h000, 0, "R6");

    repeat (4) @(negedge clk);
    chk(cke && dqm && cs_n, "R1", "reset pins cke/dqm/cs_n", {cke, dqm, cs_n}, 7);
    chk(!done && !busy, "R1", "reset flags done/busy", {done, busy}, 0);
    rst_n = 1;
    at_cyc(WAIT - 1);
    chk(cke && dqm && cs_n, "R1", "power-up wait pins", {cke, dqm, cs_n}, 7);
    at_cyc(D - 1);
    chk(!done && dqm, "R5", "done/dqm before ready", {done, dqm}, 1);
    at_cyc(D);
    chk(done && !dqm, "R5", "done/dqm at ready", {done, dqm}, 2);
    at_cyc(D + REF - 1);
    chk(!busy, "R6", "busy before interval", busy, 0);
    at_cyc(D + REF);
    chk(busy, "R6", "busy at interval", busy, 1);
    at_cyc(D + REF + TRP + TRC);
    chk(busy, "R8", "busy during refresh", busy, 1);
    at_cyc(D + REF + 1 + TRP + TRC);
    chk(!busy, "R8", "busy released", busy, 0);
    at_cyc(D + REF + 20);
    client_idle = 0;
    at_cyc(D + 2 * REF - 1);
    chk(!busy, "R6", "busy before second interval", busy, 0);
    at_cyc(D + 2 * REF);
    chk(busy, "R6", "busy at second interval", busy, 1);
    at_cyc(HOLD);
    chk(busy && done, "R7", "busy held while client active", {busy, done}, 3);
    client_idle = 1;
    at_cyc(HOLD + 1 + TRP + TRC);
    chk(!busy, "R8", "busy released after granted refresh", busy, 0);
    at_cyc(D + 3 * REF + 10);
    chk(q_cyc.size() == 0, "R6", "commands still outstanding", q_cyc.size(), 0);
    chk(done && !dqm && cke, "R5", "ready state retained", {done, dqm, cke}, 5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule